// File: doc/BRIEF.md
# Flash Toggle-Bit Status Generator

This block is the device-side status logic of a parallel NOR flash. While an embedded program or erase runs, a host polls the device by reading it, and each read returns status bits in place of array data. Two toggle bits carry that status. The first inverts on every status read while an operation is running. The second inverts only when the read lands in a sector that is marked as erasing or erase-suspended. Comparing two reads therefore tells the host both whether work is still in progress and which sectors are affected.

The operating mode, the sector bitmap and the read strobe come from elsewhere in the device: a command decoder, an erase engine and the bus interface. Each rising edge of the read strobe is one read cycle. The block registers the response of that read. A separate sticky fault bit records an operation timeout. A reset command clears the fault bit and forces idle behaviour until the mode input itself goes back to idle.

Top module: `flash_toggle_status`

## Requirements
- R1: After synchronous reset, `stat_vld_o`, `dq6_o`, `dq2_o` and `dq5_o` are all 0.
- R2: Only a 0-to-1 transition of `rd_stb_i`, sampled on `clk`, counts as a read. The response appears on the outputs one cycle after the edge is sampled. The outputs hold that response while the strobe stays high, and holding the strobe high causes no further inversions.
- R3: Mode encoding is idle=0, program=1, erase=2, suspend-read=3, suspend-program=4, and any other code acts as idle. In program mode, each read returns `stat_vld_o`=1 and `dq2_o`=1. It also returns `dq6_o` equal to the toggle state before the read, after which that state inverts.
- R4: In erase mode, `dq6_o` toggles on every read as in R3. A read whose sector bit is set in `erase_map_i` (bit index = `rd_sector_i`) returns the second toggle state on `dq2_o`, and that state then inverts. A read of an unmarked sector returns `dq2_o`=1 and leaves the second toggle state unchanged.
- R5: In suspend-read mode, a read of a marked sector returns `stat_vld_o`=1, `dq6_o`=1 and the second toggle state on `dq2_o`, which then inverts; the first toggle state does not change. A read of an unmarked sector is an array read (R7 outputs) and changes neither toggle state.
- R6: In suspend-program mode, `dq6_o` toggles on every read. A marked sector returns and inverts the second toggle state, and an unmarked sector returns `dq2_o`=1.
- R7: An array read (idle mode) returns `stat_vld_o`=0, `dq6_o`=0 and `dq2_o`=0. While the effective mode is idle, both toggle states are held at 0, so the first read of every new operation returns 0 on each toggle bit. Toggle states carry over between non-idle modes.
- R8: A `timeout_i` pulse while the effective mode is not idle sets `dq5_o` one cycle later, and `dq5_o` stays set. A pulse while the effective mode is idle is ignored.
- R9: A `reset_cmd_i` pulse clears `dq5_o` and both toggle states. From the next cycle, reads act as idle until `mode_i` has been sampled at idle, even if `mode_i` still shows an active mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 3 | Operating mode code (R3) |
| erase_map_i | input | NUM_SECT | One bit per sector, set = erasing or erase-suspended |
| rd_stb_i | input | 1 | Read strobe; each rising edge is one read |
| rd_sector_i | input | SECT_W | Sector index of the read |
| timeout_i | input | 1 | Operation timeout pulse |
| reset_cmd_i | input | 1 | Reset command pulse |
| stat_vld_o | output | 1 | 1 = last read returned status, 0 = array data |
| dq6_o | output | 1 | First toggle bit of the last read |
| dq2_o | output | 1 | Second (sector) toggle bit of the last read |
| dq5_o | output | 1 | Sticky timeout flag |

## Verification
A read response is due one cycle after the clock edge that first samples the strobe high. The bench raises the strobe just after a falling edge and checks the outputs on the next falling edge. It then checks them again after extra held-high cycles, which confirms that nothing changes until the strobe drops and rises again. `dq5_o` is due one cycle after a timeout or reset-command pulse and is sampled on the following falling edge. An abort holds until the mode input has been idle for one sampled edge, so the bench spends that cycle before it starts a new operation.

// File: rtl/flash_stat_pkg.sv
// Package: shared mode type and decode for the flash status generator.
// Assumes the mode code is 3 bits wide; unused codes decode to idle.
package flash_stat_pkg;

    typedef enum logic [2:0] {
        MD_IDLE    = 3'd0,
        MD_PROG    = 3'd1,
        MD_ERASE   = 3'd2,
        MD_SUSP_RD = 3'd3,
        MD_SUSP_PG = 3'd4
    } op_mode_e;

    // One registered read response.
    typedef struct packed {
        logic vld;
        logic dq6;
        logic dq2;
    } stat_word_t;

    // Map a raw mode code onto the enum; anything unknown is idle.
    function automatic op_mode_e decode_mode(input logic [2:0] raw);
        case (raw)
            3'd1:    return MD_PROG;
            3'd2:    return MD_ERASE;
            3'd3:    return MD_SUSP_RD;
            3'd4:    return MD_SUSP_PG;
            default: return MD_IDLE;
        endcase
    endfunction

    // True when the first toggle bit advances on a read in this mode.
    function automatic logic flips_primary(input op_mode_e m);
        return (m == MD_PROG) || (m == MD_ERASE) || (m == MD_SUSP_PG);
    endfunction

    // True when a marked-sector read advances the second toggle bit.
    function automatic logic flips_sector(input op_mode_e m);
        return (m == MD_ERASE) || (m == MD_SUSP_RD) || (m == MD_SUSP_PG);
    endfunction

endpackage

// File: rtl/strobe_edge.sv
// Module: strobe_edge
// Turns a read strobe level into a one-cycle read pulse on its rising edge.
// Assumes the strobe is already synchronous to clk.
module strobe_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic stb_i,
    output logic fire_o
);

    logic stb_q;

    // Remember the strobe level of the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) stb_q <= 1'b0;
        else        stb_q <= stb_i;
    end

    assign fire_o = stb_i && !stb_q;

    // R2: a held strobe never produces two pulses in a row.
    p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |=> !fire_o);

endmodule

// File: rtl/toggle_bit.sv
// Module: toggle_bit
// One status toggle flip-flop: cleared by clr_i, inverted by flip_i.
// Assumes clear has priority over inversion in the same cycle.
module toggle_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic flip_i,
    output logic q_o
);

    // Hold, clear or invert the toggle state.
    always_ff @(posedge clk) begin
        if (!rst_n)      q_o <= 1'b0;
        else if (clr_i)  q_o <= 1'b0;
        else if (flip_i) q_o <= ~q_o;
    end

    // R3: a qualifying read inverts the state.
    p_flip_inverts_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (flip_i && !clr_i) |=> (q_o != $past(q_o)));

    // R7: a clear leaves the state at 0.
    p_clear_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !q_o);

endmodule

// File: rtl/sector_select.sv
// Module: sector_select
// Reports whether the addressed sector is marked in the sector bitmap.
// Assumes an index beyond NUM_SECT-1 addresses no marked sector.
module sector_select #(
    parameter int NUM_SECT = 16,
    parameter int SECT_W   = $clog2(NUM_SECT)
) (
    input  logic [NUM_SECT-1:0] map_i,
    input  logic [SECT_W-1:0]   sect_i,
    output logic                hit_o
);

    logic [NUM_SECT-1:0] match;

    // One comparator per sector, masked by that sector's mark.
    for (genvar i = 0; i < NUM_SECT; i++) begin : g_cmp
        assign match[i] = map_i[i] && (sect_i == SECT_W'(i));
    end

    assign hit_o = |match;

    // R4: at most one sector matches any address.
    always_comb begin
        a_onehot_match_r4: assert ($onehot0(match));
    end

endmodule

// File: rtl/fault_flag.sv
// Module: fault_flag
// Sticky timeout flag: set by a timeout during an active operation,
// cleared only by the reset command. Clear wins over set.
module fault_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic active_i,
    input  logic timeout_i,
    input  logic clr_i,
    output logic flag_o
);

    // Set on a timeout during an operation, drop on a reset command.
    always_ff @(posedge clk) begin
        if (!rst_n)                       flag_o <= 1'b0;
        else if (clr_i)                   flag_o <= 1'b0;
        else if (timeout_i && active_i)   flag_o <= 1'b1;
    end

    // R8: once set, the flag stays set until a reset command.
    p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !clr_i) |=> flag_o);

    // R8: an idle timeout does not raise the flag.
    p_idle_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_o && !active_i) |=> !flag_o);

    // R9: the reset command clears the flag.
    p_flag_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !flag_o);

endmodule

// File: rtl/mode_gate.sv
// Module: mode_gate
// Decodes the mode input and applies the abort hold after a reset command:
// the effective mode stays idle until the raw mode has been seen idle.
module mode_gate
    import flash_stat_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] mode_i,
    input  logic       reset_cmd_i,
    output op_mode_e   eff_mode_o
);

    op_mode_e raw_mode;
    logic     abort_q;

    assign raw_mode = decode_mode(mode_i);

    // Abort latch: set by reset command, released once mode is idle.
    always_ff @(posedge clk) begin
        if (!rst_n)                  abort_q <= 1'b0;
        else if (reset_cmd_i)        abort_q <= 1'b1;
        else if (raw_mode == MD_IDLE) abort_q <= 1'b0;
    end

    assign eff_mode_o = abort_q ? MD_IDLE : raw_mode;

    // R9: the cycle after a reset command always acts as idle.
    p_abort_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        reset_cmd_i |=> (eff_mode_o == MD_IDLE));

endmodule

// File: rtl/flash_toggle_status.sv
// Module: flash_toggle_status (top)
// Produces the per-read status bits of an embedded flash operation: a
// general toggle bit, a sector toggle bit and a sticky timeout flag.
// Assumes mode, sector map and strobe are synchronous to clk.
module flash_toggle_status
    import flash_stat_pkg::*;
#(
    parameter  int NUM_SECT = 16,
    localparam int SECT_W   = $clog2(NUM_SECT)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2:0]          mode_i,
    input  logic [NUM_SECT-1:0] erase_map_i,
    input  logic                rd_stb_i,
    input  logic [SECT_W-1:0]   rd_sector_i,
    input  logic                timeout_i,
    input  logic                reset_cmd_i,
    output logic                stat_vld_o,
    output logic                dq6_o,
    output logic                dq2_o,
    output logic                dq5_o
);

    op_mode_e   eff_mode;
    logic       fire;
    logic       hit;
    logic       clr_tog;
    logic       t6_q;
    logic       t2_q;
    stat_word_t resp_d;
    stat_word_t resp_q;

    mode_gate u_mode (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_i      (mode_i),
        .reset_cmd_i (reset_cmd_i),
        .eff_mode_o  (eff_mode)
    );

    strobe_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .stb_i  (rd_stb_i),
        .fire_o (fire)
    );

    sector_select #(.NUM_SECT(NUM_SECT), .SECT_W(SECT_W)) u_sel (
        .map_i  (erase_map_i),
        .sect_i (rd_sector_i),
        .hit_o  (hit)
    );

    assign clr_tog = (eff_mode == MD_IDLE) || reset_cmd_i;

    toggle_bit u_tog6 (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (clr_tog),
        .flip_i (fire && flips_primary(eff_mode)),
        .q_o    (t6_q)
    );

    toggle_bit u_tog2 (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (clr_tog),
        .flip_i (fire && hit && flips_sector(eff_mode)),
        .q_o    (t2_q)
    );

    fault_flag u_fault (
        .clk       (clk),
        .rst_n     (rst_n),
        .active_i  (eff_mode != MD_IDLE),
        .timeout_i (timeout_i),
        .clr_i     (reset_cmd_i),
        .flag_o    (dq5_o)
    );

    // Select the response a read returns in the current mode.
    always_comb begin
        resp_d = '0;
        case (eff_mode)
            MD_PROG:    resp_d = '{vld: 1'b1, dq6: t6_q, dq2: 1'b1};
            MD_ERASE,
            MD_SUSP_PG: resp_d = '{vld: 1'b1, dq6: t6_q, dq2: hit ? t2_q : 1'b1};
            MD_SUSP_RD: resp_d = hit ? '{vld: 1'b1, dq6: 1'b1, dq2: t2_q} : '0;
            default:    resp_d = '0;
        endcase
    end

    // Capture the response on each read edge and hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)    resp_q <= '0;
        else if (fire) resp_q <= resp_d;
    end

    assign stat_vld_o = resp_q.vld;
    assign dq6_o      = resp_q.dq6;
    assign dq2_o      = resp_q.dq2;

    // R2: without a read edge the outputs do not move.
    p_hold_between_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> $stable(resp_q));

    // R7: an idle read returns array data.
    p_idle_array_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && eff_mode == MD_IDLE) |=> (!stat_vld_o && !dq6_o && !dq2_o));

    // R3: a program-mode read shows the sector bit high.
    p_prog_dq2_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && eff_mode == MD_PROG) |=> (stat_vld_o && dq2_o));

    // R5: a suspend-read status read shows the general bit steady high.
    p_susprd_dq6_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && eff_mode == MD_SUSP_RD && hit) |=> (stat_vld_o && dq6_o));

    // R6: a suspend-program read of an unmarked sector shows dq2 high.
    p_susppg_unmarked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && eff_mode == MD_SUSP_PG && !hit) |=> dq2_o);

    // R4: in erase mode the general toggle bit advances on every read.
    p_erase_dq6_flips_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && eff_mode == MD_ERASE && !reset_cmd_i) |=> (t6_q != $past(t6_q)));

endmodule

// File: tb/flash_toggle_status_tb.sv
module flash_toggle_status_tb;

    localparam int NS = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    mode = 3'd0;
    logic [NS-1:0] emap = '0;
    logic          stb = 1'b0;
    logic [3:0]    sect = '0;
    logic          tmo = 1'b0;
    logic          rcmd = 1'b0;
    logic          vld, d6, d2, d5;

    int  n_run = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    // Bench model state derived from the requirements.
    logic m6 = 1'b0;
    logic m2 = 1'b0;
    logic m5 = 1'b0;
    bit   m_abort = 1'b0;
    int   cur_mode = 0;

    always #5 clk = ~clk;

    flash_toggle_status #(.NUM_SECT(NS)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_i      (mode),
        .erase_map_i (emap),
        .rd_stb_i    (stb),
        .rd_sector_i (sect),
        .timeout_i   (tmo),
        .reset_cmd_i (rcmd),
        .stat_vld_o  (vld),
        .dq6_o       (d6),
        .dq2_o       (d2),
        .dq5_o       (d5)
    );

    task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    function automatic int eff_mode();
        if (m_abort) return 0;
        if (cur_mode > 4) return 0;
        return cur_mode;
    endfunction

    task automatic set_mode(input int m);
        @(negedge clk);
        mode = 3'(m);
        cur_mode = m;
        if (m == 0 || m > 4) begin
            @(negedge clk);   // abort releases and toggles clear at this edge
            m_abort = 1'b0;
            m6 = 1'b0;
            m2 = 1'b0;
        end
    endtask

    // One read of sector s; the strobe is held high for hold extra cycles.
    task automatic do_read(input int s, input int hold, input string tag);
        logic hit, xv, x6, x2;
        int   em;
        hit = emap[s];
        em  = eff_mode();
        xv = 1'b0; x6 = 1'b0; x2 = 1'b0;
        case (em)
            1: begin xv = 1; x6 = m6; x2 = 1; m6 = ~m6; end
            2, 4: begin
                xv = 1; x6 = m6; x2 = hit ? m2 : 1'b1;
                m6 = ~m6;
                if (hit) m2 = ~m2;
            end
            3: if (hit) begin xv = 1; x6 = 1; x2 = m2; m2 = ~m2; end
            default: ;
        endcase
        @(negedge clk);
        sect = 4'(s);
        stb  = 1'b1;
        @(negedge clk);
        check(tag, {1'b0, vld, d6, d2}, {1'b0, xv, x6, x2});
        for (int k = 0; k < hold; k++) @(negedge clk);
        if (hold > 0) check({tag, " R2 hold"}, {1'b0, vld, d6, d2}, {1'b0, xv, x6, x2});
        stb = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_timeout(input string tag);
        @(negedge clk);
        tmo = 1'b1;
        if (eff_mode() != 0) m5 = 1'b1;
        @(negedge clk);
        tmo = 1'b0;
        check(tag, {3'b0, d5}, {3'b0, m5});
    endtask

    task automatic pulse_reset(input string tag);
        @(negedge clk);
        rcmd = 1'b1;
        @(negedge clk);
        rcmd = 1'b0;
        m5 = 1'b0; m6 = 1'b0; m2 = 1'b0; m_abort = 1'b1;
        check(tag, {3'b0, d5}, 4'b0);
    endtask

    initial begin
        logic [NS-1:0] maps [5];
        maps[0] = 16'h0000; maps[1] = 16'hFFFF; maps[2] = 16'hA5C3;
        maps[3] = 16'h0001; maps[4] = 16'h8000;

        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 reset", {vld, d6, d2, d5}, 4'b0);
        rst_n = 1'b1;
        @(negedge clk);

        // R7: idle reads give array data
        for (int s = 0; s < NS; s += 5) do_read(s, 0, "R7 idle read");

        // Sweep active modes, maps and every sector with two reads each.
        for (int m = 1; m <= 4; m++) begin
            for (int p = 0; p < 5; p++) begin
                set_mode(0);
                emap = maps[p];
                set_mode(m);
                for (int s = 0; s < NS; s++) begin
                    case (m)
                        1: begin do_read(s, 0, "R3 program"); do_read(s, 0, "R3 program"); end
                        2: begin do_read(s, 0, "R4 erase");   do_read(s, 0, "R4 erase");   end
                        3: begin do_read(s, 0, "R5 susp rd"); do_read(s, 0, "R5 susp rd"); end
                        default: begin do_read(s, 0, "R6 susp pg"); do_read(s, 0, "R6 susp pg"); end
                    endcase
                end
            end
        end

        // R2: held strobe gives one read only.
        set_mode(0);
        emap = 16'h00F0;
        set_mode(2);
        do_read(5, 4, "R2 erase held");
        do_read(5, 3, "R2 erase held");
        do_read(1, 2, "R2 erase held");

        // R7: toggle state carries across active modes, then idle clears it.
        do_read(6, 0, "R7 carry erase");
        set_mode(3);
        do_read(6, 0, "R7 carry susp rd");
        do_read(2, 0, "R7 carry susp rd unmarked");
        set_mode(2);
        do_read(6, 0, "R7 carry resume");
        set_mode(0);
        set_mode(1);
        do_read(0, 0, "R7 fresh start");

        // R3: unknown mode codes act as idle.
        set_mode(7);
        do_read(4, 0, "R3 unknown code");

        // R8: timeout ignored in idle, sticky when active.
        set_mode(0);
        pulse_timeout("R8 idle timeout ignored");
        set_mode(2);
        pulse_timeout("R8 timeout sets");
        repeat (5) @(negedge clk);
        check("R8 sticky", {3'b0, d5}, 4'b0001);
        do_read(4, 0, "R8 read after timeout");
        check("R8 sticky after read", {3'b0, d5}, 4'b0001);

        // R9: reset command clears flag and forces idle until mode idles.
        pulse_reset("R9 clear flag");
        do_read(5, 0, "R9 aborted read");
        pulse_timeout("R9 timeout while aborted");
        set_mode(0);
        set_mode(2);
        do_read(5, 0, "R9 restart");
        do_read(5, 0, "R9 restart");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule